// File: doc/BRIEF.md
# Dual-buffer transmit command controller

This block is the transmit half of a small Ethernet MAC, seen from a 32-bit register port. Software fills one of two 2 KB transmit slots with frame bytes, writes that slot's byte count, and then writes the slot's control word. The control word carries a two-bit command. One value streams the slot's bytes out on a byte-wide valid/ready interface. The other value copies the first six bytes of the slot into the station address output.

Only one command runs at a time. While it runs, the start and program flags of the active slot read back as one. They clear by themselves when the command finishes. A single global enable, held in slot 0 only, gates a one-cycle interrupt pulse at completion, together with each slot's own interrupt enable. Preamble, FCS, the PHY side and collisions belong to other blocks.

Top module: `txcmd_ctrl`

## Requirements
- R1: Byte addresses 0x000–0x7FF select slot 0 and 0x800–0xFFF select slot 1. Within a slot, offset 0x7F4 is the length register (11 bits, upper bits read zero) and offset 0x7FC is the control register. Every other word is buffer storage that reads back what was last written. Read data appears on `bus_rdata` the cycle after `bus_rd`.
- R2: Bit 31 of offset 0x7F8 in slot 0 is the global interrupt enable, and the other bits of that word read zero. Offset 0xFF8 in slot 1 is plain buffer storage.
- R3: In the control word, bit 0 is start (S), bit 1 is program (P) and bit 3 is the slot interrupt enable (I). A control write with S=1, P=0 sends exactly as many bytes as the slot's length register holds.
- R4: Bytes leave in ascending address order, lowest byte of each word first. `tx_last` is high only with the final byte. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold.
- R5: A control write with S=1, P=1 loads `mac_addr`: slot byte 0 goes to bits 47:40 and so on down to slot byte 5 in bits 7:0. No byte appears on the stream.
- R6: While a command is active, its slot's control word reads S=1 (and P=1 for an address load). Once it completes, both read 0.
- R7: At completion, `irq` pulses high for one cycle if, and only if, the slot's I bit and the global enable are both set.
- R8: A control write with S=0 only stores I and starts nothing.
- R9: A control write with S=1 while a command is active starts nothing. Only its I bit is stored.
- R10: A send with length 0 emits no byte but still completes, including the interrupt.
- R11: After reset, the length, control and enable registers read 0, `tx_valid` and `irq` are low, and `mac_addr` equals the `MAC_RESET` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | 32-bit write strobe |
| bus_rd | input | 1 | 32-bit read strobe |
| bus_addr | input | 12 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | One-cycle completion pulse |
| mac_addr | output | 48 | Station address |

## Verification
A wrong byte index or word address in the sequencer shows directly on `tx_data`, in the first cycle the stream is valid after the affected word fetch. A wrong remaining-byte count shows as a missing or misplaced `tx_last`, or a byte count that differs from the length register, by the end of the frame. Decode faults and lost command state appear on the next control read: a stuck S flag never clears, and a dropped or spurious completion shows as a missing or extra `irq` pulse within a few cycles. The address-load path exposes a byte-ordering error on `mac_addr` five cycles after the command write.

// File: rtl/txc_pkg.sv
// Shared constants and types for the dual-buffer transmit command controller.
// Assumes a 32-bit register port and exactly two transmit slots.
package txc_pkg;
    localparam int CTRL_S_BIT = 0;
    localparam int CTRL_P_BIT = 1;
    localparam int CTRL_I_BIT = 3;
    localparam int GIE_BIT    = 31;
    localparam int NUM_SLOTS  = 2;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_SEND,
        ENG_MF0,
        ENG_MC0,
        ENG_MF1,
        ENG_MC1,
        ENG_DONE
    } eng_state_t;
endpackage

// File: rtl/txc_slot_ram.sv
// One transmit slot's word store. Port A serves the register bus (write and
// enabled read), port B serves the send sequencer (read every cycle).
// Assumes software never writes a word while the sequencer reads it.
// Contents are not reset.
module txc_slot_ram #(
    parameter int WORDS = 512,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [31:0]   a_wdata,
    output logic [31:0]   a_q,
    input  logic [AW-1:0] b_addr,
    output logic [31:0]   b_q
);
    logic [31:0] mem [WORDS];

    // Bus port: write-first is not needed, read returns old content.
    always_ff @(posedge clk) begin : p_port_a
        if (a_en) begin
            if (a_we) begin
                mem[a_addr] <= a_wdata;
            end
            a_q <= mem[a_addr];
        end
    end

    // Sequencer port: continuous registered read.
    always_ff @(posedge clk) begin : p_port_b
        b_q <= mem[b_addr];
    end
endmodule

// File: rtl/txc_regfile.sv
// Per-slot length and interrupt-enable registers, global enable, command
// decode and register read values. Assumes full 32-bit accesses only.
// The S/P readback comes from the sequencer's live state.
module txc_regfile
    import txc_pkg::*;
#(
    parameter int WADDR_W = 9,
    parameter int LEN_W   = 11,
    localparam int WORDS    = 1 << WADDR_W,
    localparam int LEN_OFS  = WORDS - 3,
    localparam int GIE_OFS  = WORDS - 2,
    localparam int CTRL_OFS = WORDS - 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic                          slot,
    input  logic [WADDR_W-1:0]            word,
    input  logic [31:0]                   wdata,
    input  logic                          busy,
    input  logic                          act_slot,
    input  logic                          act_mac,
    output logic [NUM_SLOTS-1:0][LEN_W-1:0] len_q,
    output logic [NUM_SLOTS-1:0]          ie_q,
    output logic                          gie_q,
    output logic                          cmd_go,
    output logic                          cmd_mac,
    output logic                          cmd_slot,
    output logic                          rd_hit,
    output logic [31:0]                   rd_val
);
    logic hit_len, hit_ctrl, hit_gie;
    logic s_live, p_live;

    // Address decode of the register words within a slot.
    always_comb begin : p_decode
        hit_len  = (word == WADDR_W'(LEN_OFS));
        hit_ctrl = (word == WADDR_W'(CTRL_OFS));
        hit_gie  = (word == WADDR_W'(GIE_OFS)) && !slot;
        rd_hit   = hit_len || hit_ctrl || hit_gie;
    end

    // Command request on a control write with the start flag set.
    always_comb begin : p_cmd
        cmd_go   = wr && hit_ctrl && wdata[CTRL_S_BIT];
        cmd_mac  = wdata[CTRL_P_BIT];
        cmd_slot = slot;
    end

    // Register storage updated by bus writes.
    always_ff @(posedge clk) begin : p_regs
        if (!rst_n) begin
            len_q <= '0;
            ie_q  <= '0;
            gie_q <= 1'b0;
        end else if (wr) begin
            if (hit_len)  len_q[slot] <= wdata[LEN_W-1:0];
            if (hit_ctrl) ie_q[slot]  <= wdata[CTRL_I_BIT];
            if (hit_gie)  gie_q       <= wdata[GIE_BIT];
        end
    end

    // Read value for the register words, including live S/P flags.
    always_comb begin : p_rdval
        s_live = busy && (act_slot == slot);
        p_live = s_live && act_mac;
        rd_val = '0;
        if (hit_len) begin
            rd_val[LEN_W-1:0] = len_q[slot];
        end else if (hit_ctrl) begin
            rd_val[CTRL_I_BIT] = ie_q[slot];
            rd_val[CTRL_P_BIT] = p_live;
            rd_val[CTRL_S_BIT] = s_live;
        end else if (hit_gie) begin
            rd_val[GIE_BIT] = gie_q;
        end
    end

    AST_CTRL_I_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_ctrl && !slot) |=> (ie_q[0] == $past(wdata[CTRL_I_BIT]))); // R8
    AST_GIE_SLOT1_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && slot) |=> $stable(gie_q)); // R2
endmodule

// File: rtl/txc_engine.sv
// Command sequencer: streams a slot's bytes (low byte of each word first)
// or loads the station address from its first six bytes, then raises a
// one-cycle interrupt when enabled. Accepts one command at a time; requests
// arriving while busy are dropped. Assumes a one-cycle registered RAM read.
module txc_engine
    import txc_pkg::*;
#(
    parameter int          WADDR_W   = 9,
    parameter int          LEN_W     = 11,
    parameter logic [47:0] MAC_RESET = 48'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_go,
    input  logic               cmd_mac,
    input  logic               cmd_slot,
    input  logic [LEN_W-1:0]   len_in,
    input  logic               ie_in,
    input  logic               gie_in,
    input  logic [31:0]        ram_q,
    output logic [WADDR_W-1:0] rd_addr,
    output logic               busy,
    output logic               act_slot,
    output logic               act_mac,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    input  logic               tx_ready,
    output logic               irq,
    output logic [47:0]        mac_addr
);
    eng_state_t       state;
    logic [1:0]       byte_idx;
    logic [LEN_W-1:0] rem;
    logic [31:0]      word0_q;
    logic [47:0]      mac_q;
    logic             irq_q;

    // Sequencer state, counters and captured address words.
    always_ff @(posedge clk) begin : p_seq
        if (!rst_n) begin
            state    <= ENG_IDLE;
            act_slot <= 1'b0;
            act_mac  <= 1'b0;
            rd_addr  <= '0;
            byte_idx <= '0;
            rem      <= '0;
            word0_q  <= '0;
            mac_q    <= MAC_RESET;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (cmd_go) begin
                        act_slot <= cmd_slot;
                        act_mac  <= cmd_mac;
                        rd_addr  <= '0;
                        byte_idx <= '0;
                        rem      <= len_in;
                        if (cmd_mac)              state <= ENG_MF0;
                        else if (len_in == '0)    state <= ENG_DONE;
                        else                      state <= ENG_FETCH;
                    end
                end
                ENG_FETCH: state <= ENG_SEND;
                ENG_SEND: begin
                    if (tx_ready) begin
                        rem <= rem - LEN_W'(1);
                        if (rem == LEN_W'(1)) begin
                            state <= ENG_DONE;
                        end else if (byte_idx == 2'd3) begin
                            byte_idx <= '0;
                            rd_addr  <= rd_addr + WADDR_W'(1);
                            state    <= ENG_FETCH;
                        end else begin
                            byte_idx <= byte_idx + 2'd1;
                        end
                    end
                end
                ENG_MF0: state <= ENG_MC0;
                ENG_MC0: begin
                    word0_q <= ram_q;
                    rd_addr <= WADDR_W'(1);
                    state   <= ENG_MF1;
                end
                ENG_MF1: state <= ENG_MC1;
                ENG_MC1: begin
                    mac_q <= {word0_q[7:0], word0_q[15:8], word0_q[23:16],
                              word0_q[31:24], ram_q[7:0], ram_q[15:8]};
                    state <= ENG_DONE;
                end
                ENG_DONE: begin
                    irq_q <= ie_in && gie_in;
                    state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Output view of the sequencer.
    always_comb begin : p_out
        busy     = (state != ENG_IDLE);
        tx_valid = (state == ENG_SEND);
        tx_data  = ram_q[8*byte_idx +: 8];
        tx_last  = tx_valid && (rem == LEN_W'(1));
        irq      = irq_q;
        mac_addr = mac_q;
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R4
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7
    AST_IRQ_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(busy)); // R7
    AST_MAC_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && act_mac) |-> !tx_valid); // R5
    AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_go) |=> (act_slot == $past(act_slot))); // R9
endmodule

// File: rtl/txcmd_ctrl.sv
// Top of the dual-buffer transmit command controller. Splits the byte
// address into slot and word, keeps one word store per slot (generated),
// and multiplexes register and buffer read data one cycle after bus_rd.
// Assumes full 32-bit accesses; bus_addr[1:0] are ignored.
module txcmd_ctrl
    import txc_pkg::*;
#(
    parameter int          SLOT_BYTES = 2048,
    parameter logic [47:0] MAC_RESET  = 48'h0,
    localparam int ADDR_W = $clog2(SLOT_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              irq,
    output logic [47:0]       mac_addr
);
    localparam int SLOT_WORDS = SLOT_BYTES / 4;
    localparam int WADDR_W    = $clog2(SLOT_WORDS);
    localparam int LEN_W      = $clog2(SLOT_BYTES);

    logic                            slot;
    logic [WADDR_W-1:0]              word;
    logic [NUM_SLOTS-1:0][31:0]      a_q, b_q;
    logic [NUM_SLOTS-1:0][LEN_W-1:0] len_q;
    logic [NUM_SLOTS-1:0]            ie_q;
    logic                            gie_q;
    logic                            cmd_go, cmd_mac, cmd_slot;
    logic                            rd_hit;
    logic [31:0]                     rd_val;
    logic [WADDR_W-1:0]              eng_addr;
    logic                            busy, act_slot, act_mac;
    logic                            rd_reg_q, rd_slot_q;
    logic [31:0]                     rd_val_q;

    // Address split into slot select and word index.
    always_comb begin : p_addr
        slot = bus_addr[ADDR_W-1];
        word = bus_addr[ADDR_W-2:2];
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        txc_slot_ram #(.WORDS(SLOT_WORDS)) i_ram (
            .clk     (clk),
            .a_en    ((bus_wr || bus_rd) && (slot == 1'(g))),
            .a_we    (bus_wr),
            .a_addr  (word),
            .a_wdata (bus_wdata),
            .a_q     (a_q[g]),
            .b_addr  (eng_addr),
            .b_q     (b_q[g])
        );
    end

    txc_regfile #(.WADDR_W(WADDR_W), .LEN_W(LEN_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .slot     (slot),
        .word     (word),
        .wdata    (bus_wdata),
        .busy     (busy),
        .act_slot (act_slot),
        .act_mac  (act_mac),
        .len_q    (len_q),
        .ie_q     (ie_q),
        .gie_q    (gie_q),
        .cmd_go   (cmd_go),
        .cmd_mac  (cmd_mac),
        .cmd_slot (cmd_slot),
        .rd_hit   (rd_hit),
        .rd_val   (rd_val)
    );

    txc_engine #(.WADDR_W(WADDR_W), .LEN_W(LEN_W), .MAC_RESET(MAC_RESET)) i_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_go   (cmd_go),
        .cmd_mac  (cmd_mac),
        .cmd_slot (cmd_slot),
        .len_in   (len_q[cmd_slot]),
        .ie_in    (ie_q[act_slot]),
        .gie_in   (gie_q),
        .ram_q    (b_q[act_slot]),
        .rd_addr  (eng_addr),
        .busy     (busy),
        .act_slot (act_slot),
        .act_mac  (act_mac),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .irq      (irq),
        .mac_addr (mac_addr)
    );

    // Capture the read source and register value at the read strobe.
    always_ff @(posedge clk) begin : p_rd_capture
        if (!rst_n) begin
            rd_reg_q  <= 1'b0;
            rd_slot_q <= 1'b0;
            rd_val_q  <= '0;
        end else if (bus_rd) begin
            rd_reg_q  <= rd_hit;
            rd_slot_q <= slot;
            rd_val_q  <= rd_val;
        end
    end

    // Read data multiplexer.
    always_comb begin : p_rdata
        bus_rdata = rd_reg_q ? rd_val_q : a_q[rd_slot_q];
    end

    AST_CTRL_S_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rd_hit && (word == WADDR_W'(SLOT_WORDS - 1)) && !busy)
        |=> (bus_rdata[CTRL_S_BIT] == 1'b0)); // R6
endmodule

// File: tb/test_txcmd_ctrl.sv
module test_txcmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_last, irq;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic [47:0] mac_addr;

    int n_chk = 0, n_err = 0;
    int cap_n = 0, irq_cnt = 0, cyc = 0, rdy_mode = 0;
    logic [7:0] cap_data [256];
    logic       cap_last [256];

    // Vector fields: [23] slot, [22:21] ready mode, [20] I, [19] global enable,
    // [18:11] pattern seed, [10:0] length.
    localparam logic [23:0] VEC [6] = '{
        {1'b0, 2'd0, 1'b1, 1'b1, 8'h11, 11'd1},
        {1'b1, 2'd1, 1'b1, 1'b1, 8'h23, 11'd7},
        {1'b0, 2'd2, 1'b0, 1'b1, 8'h35, 11'd8},
        {1'b1, 2'd0, 1'b1, 1'b0, 8'h47, 11'd13},
        {1'b0, 2'd1, 1'b1, 1'b1, 8'h59, 11'd64},
        {1'b1, 2'd2, 1'b1, 1'b1, 8'h6b, 11'd4}
    };

    txcmd_ctrl i_txcmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .irq(irq), .mac_addr(mac_addr)
    );

    always #10 clk = ~clk;

    // Drive ready away from the edge, then record handshakes and pulses.
    always @(negedge clk) begin
        cyc++;
        case (rdy_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = (cyc % 3) != 0;
            2: tx_ready = cyc[0];
            default: tx_ready = 1'b0;
        endcase
        #1;
        if (tx_valid && tx_ready && cap_n < 256) begin
            cap_data[cap_n] = tx_data;
            cap_last[cap_n] = tx_last;
            cap_n++;
        end
        if (irq) irq_cnt++;
    end

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd32(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
    endtask

    task automatic wait_idle(input logic [11:0] ctrl_a);
        logic [31:0] d;
        for (int k = 0; k < 3000; k++) begin
            rd32(ctrl_a, d);
            if (!d[0]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] bval(input int s, input int i, input int seed);
        return 8'(i * seed + s * 8'h55 + 3);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        rd32(12'h7FC, d); chk(d == 0, "R11 ctrl0", d, 0);
        rd32(12'hFF4, d); chk(d == 0, "R11 len1", d, 0);
        rd32(12'h7F8, d); chk(d == 0, "R11 gie", d, 0);
        chk(!tx_valid && !irq, "R11 valid/irq", {tx_valid, irq}, 0);
        chk(mac_addr == 48'h0, "R11 mac", mac_addr, 0);

        // R1: buffer and length storage
        wr32(12'h810, 32'hA5A55A5A); rd32(12'h810, d);
        chk(d == 32'hA5A55A5A, "R1 buffer word", d, 32'hA5A55A5A);
        wr32(12'h7F4, 32'hFFFF_F123); rd32(12'h7F4, d);
        chk(d == 32'h123, "R1 len width", d, 32'h123);

        // R2: global enable in slot 0 only
        wr32(12'h7F8, 32'hFFFF_FFFF); rd32(12'h7F8, d);
        chk(d == 32'h8000_0000, "R2 gie bit31", d, 32'h8000_0000);
        wr32(12'hFF8, 32'h1357_2468); rd32(12'hFF8, d);
        chk(d == 32'h1357_2468, "R2 slot1 plain word", d, 32'h1357_2468);
        rd32(12'h7F8, d);
        chk(d == 32'h8000_0000, "R2 gie untouched", d, 32'h8000_0000);

        // R8: S=0 stores only I
        cap_n = 0; irq_cnt = 0;
        wr32(12'hFFC, 32'h0000_0008); repeat (20) @(negedge clk);
        rd32(12'hFFC, d); chk(d == 32'h8, "R8 ctrl readback", d, 8);
        chk(cap_n == 0 && irq_cnt == 0, "R8 no command", {cap_n[15:0], irq_cnt[15:0]}, 0);

        // R3/R4/R7: vector table of sends
        foreach (VEC[v]) begin
            automatic int s    = int'(VEC[v][23]);
            automatic int mode = int'(VEC[v][22:21]);
            automatic logic ie = VEC[v][20];
            automatic logic ge = VEC[v][19];
            automatic int seed = int'(VEC[v][18:11]);
            automatic int len  = int'(VEC[v][10:0]);
            automatic logic [11:0] base = s ? 12'h800 : 12'h000;
            automatic bit ok_d = 1'b1, ok_l = 1'b1;
            wr32(12'h7F8, {ge, 31'b0});
            for (int w = 0; w < (len + 3) / 4; w++)
                wr32(base + 12'(w * 4), {bval(s, 4*w+3, seed), bval(s, 4*w+2, seed),
                                        bval(s, 4*w+1, seed), bval(s, 4*w, seed)});
            wr32(base + 12'h7F4, 32'(len));
            cap_n = 0; irq_cnt = 0; rdy_mode = mode;
            wr32(base + 12'h7FC, {28'b0, ie, 3'b001});
            wait_idle(base + 12'h7FC);
            rdy_mode = 0;
            chk(cap_n == len, "R3 byte count", 48'(cap_n), 48'(len));
            for (int i = 0; i < len && i < cap_n; i++) begin
                if (cap_data[i] != bval(s, i, seed)) ok_d = 1'b0;
                if (cap_last[i] != (i == len - 1)) ok_l = 1'b0;
            end
            chk(ok_d, "R4 byte order", 48'(cap_data[0]), 48'(bval(s, 0, seed)));
            chk(ok_l, "R4 last flag", 48'(cap_last[len-1]), 1);
            chk(irq_cnt == int'(ie && ge), "R7 irq gating", 48'(irq_cnt), 48'(ie && ge));
            rd32(base + 12'h7FC, d);
            chk(d == {28'b0, ie, 3'b000}, "R6 S/P cleared", d, {28'b0, ie, 3'b000});
        end

        // R5/R6: address load from slot 1
        wr32(12'h7F8, 32'h8000_0000);
        wr32(12'h800, 32'h4433_2211); wr32(12'h804, 32'h0000_6655);
        cap_n = 0; irq_cnt = 0;
        wr32(12'hFFC, 32'h0000_000B);
        rd32(12'hFFC, d); chk(d[1:0] == 2'b11, "R6 S/P live", d[1:0], 3);
        wait_idle(12'hFFC);
        chk(mac_addr == 48'h1122_3344_5566, "R5 mac load", mac_addr, 48'h1122_3344_5566);
        chk(cap_n == 0, "R5 no stream", 48'(cap_n), 0);
        chk(irq_cnt == 1, "R7 irq after load", 48'(irq_cnt), 1);

        // R9: start while busy is dropped
        wr32(12'h7F4, 32'd5);
        cap_n = 0; rdy_mode = 3;
        wr32(12'h7FC, 32'h1);
        rd32(12'h7FC, d); chk(d == 32'h1, "R6 S live during send", d, 1);
        wr32(12'hFFC, 32'h1);
        rd32(12'hFFC, d); chk(d == 32'h0, "R9 slot1 not started", d, 0);
        rdy_mode = 0;
        wait_idle(12'h7FC);
        repeat (40) @(negedge clk);
        chk(cap_n == 5, "R9 only slot0 bytes", 48'(cap_n), 5);

        // R10: zero length
        wr32(12'h7F4, 32'd0);
        cap_n = 0; irq_cnt = 0;
        wr32(12'h7FC, 32'h9);
        wait_idle(12'h7FC);
        chk(cap_n == 0, "R10 no bytes", 48'(cap_n), 0);
        chk(irq_cnt == 1, "R10 completes", 48'(irq_cnt), 1);
        rd32(12'h7FC, d); chk(d == 32'h8, "R10 ctrl readback", d, 8);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule